// File: doc/BRIEF.md
# Deadband Sample Compressor with Time Tag

This block thins out a stream of 12-bit converter samples before they reach a channel FIFO. It holds the last sample it stored as a reference. Each new sample is compared against a window that runs from the reference minus a lower offset up to the reference plus an upper offset. Software sets both offsets, so the window can be lopsided. A sample inside the window is dropped. A sample that leaves the window is written out together with a time tag, and it becomes the new reference.

The time tag is a 20-bit count of accepted sample strobes. The gap between two stored tags, minus one, is the number of samples discarded between them. A raw mode bypasses the window and stores every sample. Clearing the enable drops the reference, the tag count and the overflow flag, so the next run starts clean. The first sample of that run is always stored.

Top module: `dbz_compressor`

## Requirements
- R1: While reset is held and after it is released, `wr_en` and `ovf` are 0. The tag counter starts from 0.
- R2: The first sample accepted after reset or after `en` rises is stored whatever its value, provided the FIFO has room.
- R3: A sample with lower limit <= sample <= upper limit is not written. Both limits count as inside the window.
- R4: A sample outside the window is written with `wr_en` high for exactly one cycle, in the cycle after its strobe. `wr_data[11:0]` holds the sample and `wr_data[31:12]` holds its tag.
- R5: A stored sample becomes the reference for the window of every later sample.
- R6: The lower limit is max(ref - lo_ofs, 0) and the upper limit is min(ref + hi_ofs, 4095). The limits never wrap.
- R7: While `raw_mode` is 1, every accepted sample is written.
- R8: The tag attached to a sample equals the number of strobes accepted since the last enable or reset, not counting that sample. Cycles with no strobe do not advance it. It is 20 bits wide and wraps.
- R9: If `fifo_full` is high in the strobe cycle of a sample that would be stored, nothing is written, `ovf` is set and stays set, and the reference is unchanged.
- R10: While `en` is 0, strobes are ignored and nothing is written. `ovf` is cleared, and the reference and tag counter are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low clears the run state |
| raw_mode | input | 1 | Store every sample, bypassing the window |
| lo_ofs | input | 12 | Offset below the reference for the lower limit |
| hi_ofs | input | 12 | Offset above the reference for the upper limit |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample value |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 32 | {tag[19:0], sample[11:0]} |
| ovf | output | 1 | Sticky: a sample was lost to a full FIFO |

## Verification
A wrong reference shows up at the ports as soon as the next few samples arrive. Samples near the window edges are written when they should be dropped, or dropped when they should be written. The sweeps step sample values one code at a time across both limits for several offset pairs, so an error of one code in a limit or in the reference is caught on the next strobe. A tag counter that is off shows up in the high field of the very next write. An overflow path that wrongly updates the reference is exposed by the first sample after the full cycle.

// File: rtl/dbz_pkg.sv
package dbz_pkg;
    localparam int SMP_W   = 12;
    localparam int TAG_W   = 20;
    localparam int REC_W   = SMP_W + TAG_W;
    localparam logic [SMP_W-1:0] SMP_MAX = {SMP_W{1'b1}};

    typedef logic [SMP_W-1:0] smp_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        tag_t tag;
        smp_t smp;
    } rec_t;

    typedef struct packed {
        smp_t lo;
        smp_t hi;
    } win_t;

    // reference minus offset, clamped at zero
    function automatic smp_t floor_sub(smp_t r, smp_t o);
        return (r > o) ? smp_t'(r - o) : '0;
    endfunction

    // reference plus offset, clamped at full scale
    function automatic smp_t ceil_add(smp_t r, smp_t o);
        logic [SMP_W:0] s;
        s = {1'b0, r} + {1'b0, o};
        return s[SMP_W] ? SMP_MAX : s[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/dbz_window.sv
module dbz_window
    import dbz_pkg::*;
(
    input  smp_t ref_smp,
    input  smp_t lo_ofs,
    input  smp_t hi_ofs,
    input  smp_t smp,
    output logic in_win
);
    win_t lim;

    always_comb begin
        lim.lo = floor_sub(ref_smp, lo_ofs);
        lim.hi = ceil_add(ref_smp, hi_ofs);
        in_win = (smp >= lim.lo) && (smp <= lim.hi);
    end
endmodule

// File: rtl/dbz_tagger.sv
module dbz_tagger
    import dbz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output tag_t tag
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            tag <= '0;
        else if (adv)
            tag <= tag + tag_t'(1);
    end
endmodule

// File: rtl/dbz_refkeep.sv
module dbz_refkeep
    import dbz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  smp_t smp,
    output smp_t ref_smp,
    output logic ref_vld
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ref_smp <= '0;
            ref_vld <= 1'b0;
        end else if (load) begin
            ref_smp <= smp;
            ref_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/dbz_compressor.sv
module dbz_compressor
    import dbz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             raw_mode,
    input  logic [SMP_W-1:0] lo_ofs,
    input  logic [SMP_W-1:0] hi_ofs,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             fifo_full,
    output logic             wr_en,
    output logic [REC_W-1:0] wr_data,
    output logic             ovf
);
    logic accept, keep, commit, in_win, ref_vld;
    smp_t ref_smp;
    tag_t tag;
    rec_t rec_q;

    assign accept = en && smp_vld;
    assign keep   = accept && (!ref_vld || raw_mode || !in_win);
    assign commit = keep && !fifo_full;

    dbz_window u_win (
        .ref_smp (ref_smp),
        .lo_ofs  (lo_ofs),
        .hi_ofs  (hi_ofs),
        .smp     (smp_data),
        .in_win  (in_win)
    );

    dbz_tagger u_tag (
        .clk (clk),
        .rst (rst),
        .clr (!en),
        .adv (accept),
        .tag (tag)
    );

    dbz_refkeep u_ref (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en),
        .load    (commit),
        .smp     (smp_data),
        .ref_smp (ref_smp),
        .ref_vld (ref_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en <= 1'b0;
            rec_q <= '0;
            ovf   <= 1'b0;
        end else begin
            wr_en <= commit;
            if (commit)
                rec_q <= '{tag: tag, smp: smp_data};
            if (!en)
                ovf <= 1'b0;
            else if (keep && fifo_full)
                ovf <= 1'b1;
        end
    end

    assign wr_data = rec_q;
endmodule

// File: rtl/dbz_checker.sv
module dbz_checker
    import dbz_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             raw_mode,
    input logic             smp_vld,
    input logic [SMP_W-1:0] smp_data,
    input logic             fifo_full,
    input logic             wr_en,
    input logic [REC_W-1:0] wr_data,
    input logic             ovf
);
    p_no_write_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !wr_en);

    p_ovf_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !ovf);

    p_write_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(smp_vld));

    p_write_payload_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_data[SMP_W-1:0] == $past(smp_data));

    p_no_write_when_full_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(fifo_full));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf && en) |=> ovf);

    p_raw_stores_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && en && raw_mode && !fifo_full) |=> wr_en);
endmodule

bind dbz_compressor dbz_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .raw_mode  (raw_mode),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ovf       (ovf)
);

// File: tb/dbz_compressor_tb.sv
module dbz_compressor_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        raw_mode = 1'b0;
    logic [11:0] lo_ofs = '0;
    logic [11:0] hi_ofs = '0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_data = '0;
    logic        fifo_full = 1'b0;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        ovf;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int m_ref = 0, m_tag = 0;
    bit m_have = 0, m_ovf = 0;

    always #4 clk = ~clk;

    dbz_compressor u_dut (
        .clk(clk), .rst(rst), .en(en), .raw_mode(raw_mode),
        .lo_ofs(lo_ofs), .hi_ofs(hi_ofs), .smp_vld(smp_vld),
        .smp_data(smp_data), .fifo_full(fifo_full),
        .wr_en(wr_en), .wr_data(wr_data), .ovf(ovf)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one strobe; outputs checked one clock later
    task automatic send(int s, bit full, string lbl);
        int lo, hi;
        bit store, wr;
        string req;
        int exp_d;
        @(negedge clk);
        smp_vld = 1'b1; smp_data = 12'(s); fifo_full = full;
        lo = (m_ref > lo_ofs) ? m_ref - int'(lo_ofs) : 0;
        hi = (m_ref + int'(hi_ofs) > 4095) ? 4095 : m_ref + int'(hi_ofs);
        store = !m_have || raw_mode || s < lo || s > hi;
        wr = store && !full;
        if (!m_have) req = "R2 R8";
        else if (full && store) req = "R9";
        else if (raw_mode) req = "R7 R8";
        else if (store) req = "R4 R5 R8";
        else req = "R3";
        if (lbl != "") req = lbl;
        exp_d = (m_tag << 12) | s;
        if (store && full) m_ovf = 1;
        if (wr) begin m_ref = s; m_have = 1; end
        @(negedge clk);
        smp_vld = 1'b0; fifo_full = 1'b0;
        check(req, wr_en, wr);
        if (wr) check(req, wr_data, exp_d);
        check({req, " R9 ovf"}, ovf, m_ovf);
        m_tag = (m_tag + 1) & 20'hFFFFF;
    endtask

    task automatic restart();
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        m_have = 0; m_tag = 0; m_ovf = 0;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check("R1 wr_en", wr_en, 0);
        check("R1 ovf", ovf, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 wr_en after", wr_en, 0);
        en = 1'b1;

        // window sweeps over several offset pairs
        for (int c = 0; c < 4; c++) begin
            lo_ofs = (c == 0) ? 12'd5 : (c == 1) ? 12'd0 : (c == 2) ? 12'd3 : 12'd12;
            hi_ofs = (c == 0) ? 12'd9 : (c == 1) ? 12'd0 : (c == 2) ? 12'd0 : 12'd2;
            restart();
            send(100, 0, "");
            for (int s = 60; s <= 140; s++) begin
                send(s, 0, "");
                if (s % 7 == 0) @(negedge clk); // idle gap, tag must hold (R8)
            end
            for (int s = 140; s >= 60; s--) send(s, 0, "");
        end

        // exact-edge probing around a fixed reference
        lo_ofs = 12'd4; hi_ofs = 12'd6;
        for (int d = -6; d <= 8; d++) begin
            restart();
            send(1000, 0, "");
            send(1000 + d, 0, "");
        end

        // saturation at both ends (R6)
        lo_ofs = 12'd50; hi_ofs = 12'd100;
        restart();
        send(10, 0, "R2");
        send(0, 0, "R6 low clamp");
        send(10, 0, "R6");
        send(4050, 0, "R6 store");
        send(4095, 0, "R6 high clamp");
        send(3999, 0, "R6 below");

        // raw mode stores repeats (R7)
        raw_mode = 1'b1;
        for (int k = 0; k < 20; k++) send(3999, 0, "R7");
        raw_mode = 1'b0;

        // full FIFO: drop, flag, reference kept (R9)
        lo_ofs = 12'd5; hi_ofs = 12'd5;
        restart();
        send(500, 0, "R2");
        send(700, 1, "R9 drop");
        send(503, 0, "R9 ref kept");
        send(600, 0, "R9 later store");
        send(300, 1, "R9 again");

        // disable: strobes ignored, flag cleared (R10)
        @(negedge clk); en = 1'b0; smp_vld = 1'b1; smp_data = 12'd42;
        @(negedge clk); smp_vld = 1'b0;
        check("R10 no write", wr_en, 0);
        check("R10 ovf clear", ovf, 0);
        @(negedge clk); en = 1'b1;
        m_have = 0; m_tag = 0; m_ovf = 0;
        send(600, 0, "R2 R10 restart tag0");

        // pseudo-random walk
        for (int c = 0; c < 3; c++) begin
            lo_ofs = 12'(8 << c); hi_ofs = 12'(20 >> c);
            restart();
            for (int k = 0; k < 300; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                send(2048 + int'(lfsr[6:0]) - 64, lfsr[11] & lfsr[12] & lfsr[13], "");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule